// File: doc/BRIEF.md
# Eight-Lane Serial Transmit Controller

This block sits in front of eight parallel-to-serial transmit lanes. Each lane takes a 10-bit parallel word and sends it as a serial bit stream, one bit per clock. Every lane output is a serial bit plus an output-enable. When the enable is low, the lane is treated as being in high impedance. A simple acquisition counter stands in for the clock-multiplier lock. Nothing flows until that counter has finished after global power is applied.

The block has two power controls, and they behave differently. The global power input drops the lock, so a full acquisition must run again when it returns. Each lane also has its own sleep input. Sleep silences only that lane and leaves the lock alone. When sleep is released, the lane comes back after a short fixed delay and does not re-acquire.

A global output enable masks all lanes without disturbing their state. A per-lane sync request replaces the data word with a fixed alignment word. For at-speed line tests, a built-in PRBS-7 source can be routed to one chosen lane or to all lanes at once.

Top module: `sertx_ctrl`

## Requirements
- R1: With `pwr_on` low at a clock edge, `locked` is low after that edge and every bit of `ser_oe` is 0.
- R2: After `pwr_on` goes high, `locked` rises exactly LOCK_CYCLES+1 edges later, counting the first edge that sees `pwr_on` high. Until then, `ser_oe` stays all zero.
- R3: With `ch_sleep[i]` high at an edge, `ser_oe[i]` is 0 after that edge. The other lanes keep their output enables.
- R4: Releasing `ch_sleep[i]` while locked leaves `locked` high throughout. `ser_oe[i]` returns exactly WAKE_CYCLES+1 edges after the first edge that sees the release.
- R5: `out_en` low forces `ser_oe` to all zeros in the same cycle. Raising it again resumes the stream at the bit it would have reached anyway.
- R6: `word_tick` is high for one cycle in every 10 while locked. `par_data` lane i is bits [10i+9:10i]. The word present in a tick cycle is captured at the closing edge. Its bit k (LSB first) appears on `ser_bit[i]` during the (k+1)-th cycle after that edge.
- R7: If `sync_req[i]` is high at a capture edge, lane i sends SYNC_WORD (default 10'h17C) instead of its data, LSB first.
- R8: With `bist_on` high and `bist_sel` in 0..7, only lane `bist_sel` carries the PRBS stream. With `bist_sel` equal to 8, all eight lanes carry it.
- R9: With `bist_sel` in 9..15, or with `bist_on` low, no lane carries the PRBS stream. Every lane serializes its data.
- R10: The PRBS is x^7+x^6+1 in a 7-bit register seeded 7'h7F. The output is register bit 6. Each locked, awake cycle shifts left, with bit6 XOR bit5 entering at bit 0. The stream starts at the seed in the first enabled cycle.
- R11: While `rst_n` is low, `locked`, `word_tick` and `ser_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on | input | 1 | Global power: low stops the lock and silences all lanes |
| ch_sleep | input | 8 | Per-lane sleep request, high to sleep |
| out_en | input | 1 | Global output enable |
| sync_req | input | 8 | Per-lane request to send the alignment word |
| bist_on | input | 1 | Enables the PRBS test pattern |
| bist_sel | input | 4 | PRBS target: 0..7 one lane, 8 all lanes, 9..15 none |
| par_data | input | 80 | Parallel words, 10 bits per lane |
| ser_bit | output | 8 | Serial data per lane |
| ser_oe | output | 8 | Per-lane output enable (low means high impedance) |
| locked | output | 1 | Lock acquired |
| word_tick | output | 1 | Word capture cycle marker |

## Verification
The bench builds the block with LOCK_CYCLES = 20 and WAKE_CYCLES = 4, and keeps the lane count and word width at their defaults. The short lock window lets the bench walk the full acquisition edge by edge twice, once after reset and once after a global power cycle. The four-cycle wake delay lets it confirm the exact edge at which a sleeping lane returns while the lock stays held. With these sizes, the PRBS checks and the word-by-word serialization checks all fit well inside a short run.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    PLL_OFF = 2'd0,
    PLL_ACQ = 2'd1,
    PLL_LOCK = 2'd2
  } lock_st_t;

  typedef enum logic [1:0] {
    CH_SLEEP = 2'd0,
    CH_WAKE = 2'd1,
    CH_LIVE = 2'd2
  } ch_st_t;

  localparam int PRBS_W = 7;
  localparam logic [PRBS_W-1:0] PRBS_SEED = '1;

  // One step of the x^7 + x^6 + 1 generator: shift left, feed back b6^b5.
  function automatic logic [PRBS_W-1:0] prbs7_step(input logic [PRBS_W-1:0] s);
    return {s[PRBS_W-2:0], s[6] ^ s[5]};
  endfunction

  // Word-position counter with wrap.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned last);
    return (v == last) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/sertx_lock.sv
module sertx_lock
  import sertx_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024,
  parameter int WORD_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  output logic locked,
  output logic tick
);
  localparam int LC_W = $clog2(LOCK_CYCLES + 1);
  localparam int BC_W = $clog2(WORD_W);

  lock_st_t st;
  logic [LC_W-1:0] lcnt;
  logic [BC_W-1:0] bcnt;
  logic acq_done;

  assign acq_done = (st == PLL_ACQ) && (lcnt == LC_W'(LOCK_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= PLL_OFF;
      lcnt <= '0;
      bcnt <= '0;
    end else if (!pwr_on) begin
      st   <= PLL_OFF;
      lcnt <= '0;
      bcnt <= '0;
    end else begin
      case (st)
        PLL_OFF: begin
          st   <= PLL_ACQ;
          lcnt <= '0;
        end
        PLL_ACQ: begin
          if (acq_done) st <= PLL_LOCK;
          else lcnt <= lcnt + 1'b1;
        end
        PLL_LOCK: bcnt <= BC_W'(wrap_inc(int'(bcnt), WORD_W - 1));
        default: st <= PLL_OFF;
      endcase
    end
  end

  assign locked = (st == PLL_LOCK);
  assign tick   = locked && (bcnt == '0);

  AST_PWROFF_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !locked); // R1
  AST_LOCK_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(st) == PLL_ACQ) && $past(pwr_on)); // R2
  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && pwr_on) |=> locked); // R4
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R6

endmodule

// File: rtl/sertx_chan.sv
module sertx_chan
  import sertx_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int WAKE_CYCLES = 16,
  parameter logic [WORD_W-1:0] SYNC_WORD = 10'h17C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              locked,
  input  logic              tick,
  input  logic              sleep_req,
  input  logic              sync_req,
  input  logic              bist_en,
  input  logic              out_en,
  input  logic [WORD_W-1:0] word_in,
  output logic              ser_bit,
  output logic              ser_oe
);
  localparam int WC_W = $clog2(WAKE_CYCLES + 1);

  ch_st_t st;
  logic [WC_W-1:0] wcnt;
  logic [WORD_W-1:0] sreg;
  logic [PRBS_W-1:0] lfsr;
  logic live, run, wake_done, load_now;

  assign wake_done = (st == CH_WAKE) && (wcnt == WC_W'(WAKE_CYCLES - 1));
  assign live      = (st == CH_LIVE);
  assign run       = live && locked;
  assign load_now  = run && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= CH_LIVE;
      wcnt <= '0;
    end else if (sleep_req) begin
      st   <= CH_SLEEP;
      wcnt <= '0;
    end else begin
      case (st)
        CH_SLEEP: begin
          wcnt <= '0;
          st   <= locked ? CH_WAKE : CH_LIVE;
        end
        CH_WAKE: begin
          if (wake_done || !locked) st <= CH_LIVE;
          else wcnt <= wcnt + 1'b1;
        end
        default: st <= CH_LIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg <= '0;
    else if (!run) sreg <= '0;
    else if (load_now) sreg <= sync_req ? SYNC_WORD : word_in;
    else sreg <= sreg >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= PRBS_SEED;
    else if (!bist_en) lfsr <= PRBS_SEED;
    else if (run) lfsr <= prbs7_step(lfsr);
  end

  assign ser_bit = bist_en ? lfsr[PRBS_W-1] : sreg[0];
  assign ser_oe  = out_en && run;

  AST_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> !ser_oe); // R3
  AST_WAKE_VIA_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(live) && $past(locked)) |-> ($past(st) == CH_WAKE)); // R4
  AST_PRBS_FROM_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bist_en) |-> (lfsr == PRBS_SEED)); // R10

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int NCH = 8,
  parameter int WORD_W = 10,
  parameter int LOCK_CYCLES = 1024,
  parameter int WAKE_CYCLES = 16,
  parameter logic [WORD_W-1:0] SYNC_WORD = 10'h17C,
  localparam int SEL_W = $clog2(NCH) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_on,
  input  logic [NCH-1:0]        ch_sleep,
  input  logic                  out_en,
  input  logic [NCH-1:0]        sync_req,
  input  logic                  bist_on,
  input  logic [SEL_W-1:0]      bist_sel,
  input  logic [NCH*WORD_W-1:0] par_data,
  output logic [NCH-1:0]        ser_bit,
  output logic [NCH-1:0]        ser_oe,
  output logic                  locked,
  output logic                  word_tick
);
  localparam logic [SEL_W-1:0] SEL_ALL = SEL_W'(NCH);

  logic [NCH-1:0] bist_en;

  sertx_lock #(.LOCK_CYCLES(LOCK_CYCLES), .WORD_W(WORD_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on),
    .locked(locked), .tick(word_tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    assign bist_en[i] = bist_on && ((bist_sel == SEL_W'(i)) || (bist_sel == SEL_ALL));

    sertx_chan #(.WORD_W(WORD_W), .WAKE_CYCLES(WAKE_CYCLES), .SYNC_WORD(SYNC_WORD)) u_chan (
      .clk(clk), .rst_n(rst_n), .locked(locked), .tick(word_tick),
      .sleep_req(ch_sleep[i]), .sync_req(sync_req[i]), .bist_en(bist_en[i]),
      .out_en(out_en), .word_in(par_data[i*WORD_W +: WORD_W]),
      .ser_bit(ser_bit[i]), .ser_oe(ser_oe[i])
    );
  end

  AST_BIST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_sel != SEL_ALL) |-> ($countones(bist_en) <= 1)); // R8
  AST_BIST_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bist_on || (bist_sel > SEL_ALL)) |-> (bist_en == '0)); // R9
  AST_OFF_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (ser_oe == '0)); // R1

endmodule

// File: tb/sertx_ctrl_bench.sv
module sertx_ctrl_bench;
  localparam int NCH = 8;
  localparam int WW = 10;
  localparam int LOCKC = 20;
  localparam int WAKEC = 4;
  localparam logic [WW-1:0] SYNCW = 10'h17C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on = 1'b0;
  logic [NCH-1:0] ch_sleep = '0;
  logic out_en = 1'b1;
  logic [NCH-1:0] sync_req = '0;
  logic bist_on = 1'b0;
  logic [3:0] bist_sel = '0;
  logic [NCH*WW-1:0] par_data = '0;
  logic [NCH-1:0] ser_bit, ser_oe;
  logic locked, word_tick;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sertx_ctrl #(.NCH(NCH), .WORD_W(WW), .LOCK_CYCLES(LOCKC), .WAKE_CYCLES(WAKEC),
               .SYNC_WORD(SYNCW)) u_sertx_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .ch_sleep(ch_sleep), .out_en(out_en),
    .sync_req(sync_req), .bist_on(bist_on), .bist_sel(bist_sel), .par_data(par_data),
    .ser_bit(ser_bit), .ser_oe(ser_oe), .locked(locked), .word_tick(word_tick)
  );

  // stimulus table: bit 10 = sync request, bits 9:0 = data word
  localparam logic [10:0] VEC [6] = '{
    {1'b0, 10'h2B5}, {1'b0, 10'h3FF}, {1'b0, 10'h000},
    {1'b1, 10'h0F0}, {1'b0, 10'h155}, {1'b0, 10'h001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent restatement of the PRBS-7 update
  function automatic logic [6:0] model_next(input logic [6:0] m);
    logic fb;
    fb = m[6] ^ m[5];
    return (m << 1) | {6'd0, fb};
  endfunction

  task automatic send_word(input logic [WW-1:0] w, input logic sy, input string req);
    logic [WW-1:0] exp_w;
    while (!word_tick) @(negedge clk);
    par_data = {NCH{w}};
    sync_req = {NCH{sy}};
    exp_w = sy ? SYNCW : w;
    for (int k = 0; k < WW; k++) begin
      @(negedge clk);
      check({req, " lane0 bit"}, ser_bit[0], exp_w[k]);
      check({req, " lane7 bit"}, ser_bit[7], exp_w[k]);
    end
    check({req, " oe"}, ser_oe, {NCH{1'b1}});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] m;
    logic [WW-1:0] w;
    repeat (3) @(negedge clk);
    check("R11 locked", locked, 0);
    check("R11 tick", word_tick, 0);
    check("R11 oe", ser_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    pwr_on = 1'b1;
    for (int e = 1; e <= LOCKC + 1; e++) begin
      @(negedge clk);
      check("R2 lock edge", locked, (e == LOCKC + 1));
      if (e <= LOCKC) check("R2 oe quiet", ser_oe, 0);
    end

    // table walk: serialization and sync words
    for (int v = 0; v < 6; v++)
      send_word(VEC[v][9:0], VEC[v][10], VEC[v][10] ? "R7" : "R6");
    sync_req = '0;

    // output enable drop mid word
    while (!word_tick) @(negedge clk);
    w = 10'h0F3;
    par_data = {NCH{w}};
    for (int k = 0; k < WW; k++) begin
      @(negedge clk);
      if (k == 3) out_en = 1'b0;
      if (k == 5) out_en = 1'b1;
      #1;
      if (k == 3 || k == 4) check("R5 oe masked", ser_oe, 0);
      else begin
        check("R5 bit resumes", ser_bit[0], w[k]);
        check("R5 oe back", ser_oe, {NCH{1'b1}});
      end
    end

    // BIST on a single lane, others idle at zero data
    send_word(10'h000, 1'b0, "R6 zero");
    send_word(10'h000, 1'b0, "R6 zero");
    bist_sel = 4'd3;
    bist_on = 1'b1;
    #1;
    m = 7'h7F;
    for (int n = 0; n < 30; n++) begin
      check("R10 lane3 prbs", ser_bit[3], m[6]);
      check("R8 lane4 data", ser_bit[4], 0);
      @(negedge clk);
      #1;
      m = model_next(m);
    end
    bist_on = 1'b0;
    @(negedge clk);
    bist_sel = 4'd8;
    bist_on = 1'b1;
    #1;
    m = 7'h7F;
    for (int n = 0; n < 20; n++) begin
      check("R8 all lanes prbs", ser_bit, {NCH{m[6]}});
      @(negedge clk);
      #1;
      m = model_next(m);
    end
    bist_sel = 4'd11;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      #1;
      check("R9 sel 11 no prbs", ser_bit, 0);
    end
    bist_on = 1'b0;
    bist_sel = 4'd3;
    @(negedge clk);
    #1;
    check("R9 bist off", ser_bit, 0);

    // per-lane sleep and wake
    ch_sleep[2] = 1'b1;
    @(negedge clk);
    check("R3 lane2 quiet", ser_oe, 8'hFB);
    @(negedge clk);
    ch_sleep[2] = 1'b0;
    for (int e = 1; e <= WAKEC + 1; e++) begin
      @(negedge clk);
      check("R4 wake edge", ser_oe[2], (e == WAKEC + 1));
      check("R4 lock held", locked, 1);
    end

    // global power cycle
    pwr_on = 1'b0;
    @(negedge clk);
    check("R1 unlocked", locked, 0);
    check("R1 oe quiet", ser_oe, 0);
    pwr_on = 1'b1;
    for (int e = 1; e <= LOCKC + 1; e++) begin
      @(negedge clk);
      check("R2 relock edge", locked, (e == LOCKC + 1));
    end
    send_word(10'h1C6, 1'b0, "R6 after relock");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule